// File: doc/BRIEF.md
# Sixteen-bit timer waveform generator

A 16-bit counter with a 4-bit mode selector that produces two waveform pins, A and B. The mode sets four things: whether the counter runs single-slope (up, then wrap) or dual-slope (up, then down). It sets where the TOP value comes from: a fixed constant, the active compare A value, or a capture register. It sets when compare writes become active. It sets on which tick the overflow pulse fires. Each pin has a 2-bit output action that sets how a compare match, and the wrap in fast PWM, drive the pin.

Software-side registers are reached through one shared write-data bus with four write enables: compare A, compare B, capture and mode. The mode uses `wdata[3:0]`. The counter advances only on cycles where `tick` is high. Flag outputs are single-cycle pulses. The pulse appears in the cycle after the tick that caused it, together with the new counter value. In modes 0, 4 and 12, two force strobes can apply a pin action without any match taking place.

Top module: `tmr16_wavegen`

## Requirements
- R1: Reset clears the counter, both pins, all flags, both compare values, the capture value and the mode (mode 0).
- R2: The counter and all flags are unchanged on cycles where `tick` is low.
- R3: Mode 0 counts up from 0 to 0xFFFF and wraps to 0. The tick at 0xFFFF raises `ovf` for one cycle.
- R4: Modes 4 and 12 clear the counter to 0 on the tick where the count equals TOP. TOP is active compare A in mode 4 and the capture value in mode 12.
- R5: Fast PWM modes 5, 6 and 7 use TOP 0x00FF, 0x01FF and 0x03FF. Mode 14 takes TOP from the capture value and mode 15 from active compare A. The tick at TOP returns the counter to 0 and raises `ovf`.
- R6: Dual-slope modes count up to TOP, turn around on the tick at TOP, count down to 0, and turn up on the tick at 0. That tick sets the count to 1 and raises `ovf`. Modes 1, 2 and 3 use fixed TOP 0x00FF, 0x01FF and 0x03FF. Modes 8 and 10 take TOP from the capture value, and modes 9 and 11 from active compare A.
- R7: A compare write takes effect at once in modes 0, 4 and 12. In all other modes it is held in a buffer. The buffer is copied to the active value on the wrap tick at TOP in fast PWM modes, and on the tick that leaves 0 in modes 8 and 9. In modes 1, 2, 3, 10 and 11 it is copied on the turn-around tick at TOP.
- R8: In fast PWM, action 2 clears the pin on a match tick and sets it on the wrap tick. Action 3 is the inverse.
- R9: In dual-slope modes, action 2 clears the pin on a match while moving up and sets it on a match while moving down. The tick at TOP counts as moving down and the tick at 0 as moving up. Action 3 is the inverse.
- R10: In modes 0, 4 and 12, a match applies action 1 (toggle), 2 (clear) or 3 (set). Action 0 leaves the pin unchanged.
- R11: In modes 0, 4 and 12, a force strobe applies the pin's action in the next cycle without a tick. It raises no match flag and does not move the counter. In PWM modes the strobe has no effect on the pin.
- R12: In mode 13 the counter and both pins hold their values, even with ticks or force strobes.
- R13: `match_a`/`match_b` pulse for one cycle after a tick on which the count equals that channel's active compare value.
- R14: In fast PWM with compare equal to TOP, the set at wrap overrides the clear from the match on the same tick. Action 2 then keeps the pin high, while the match flag still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable |
| wdata | input | 16 | Shared register write data |
| wr_cmp_a | input | 1 | Write compare A |
| wr_cmp_b | input | 1 | Write compare B |
| wr_cap | input | 1 | Write capture value |
| wr_mode | input | 1 | Write mode from wdata[3:0] |
| force_a | input | 1 | Force-compare strobe, pin A |
| force_b | input | 1 | Force-compare strobe, pin B |
| om_a | input | 2 | Output action, pin A |
| om_b | input | 2 | Output action, pin B |
| count | output | 16 | Counter value |
| wave_a | output | 1 | Waveform pin A |
| wave_b | output | 1 | Waveform pin B |
| ovf | output | 1 | Overflow pulse |
| match_a | output | 1 | Compare A match pulse |
| match_b | output | 1 | Compare B match pulse |

## Verification
The set-at-wrap and clear-on-match actions can land on the same tick in fast PWM. The bench provokes this by loading compare A with 0x00FF in mode 5. It then runs through two full wraps and expects the pin to stay high while `match_a` still pulses. A second overlap comes from a buffered compare write in the same period where the old active value is still matching. The bench judges this by watching the match pulse at the old value, then the pin edge at the new value only after the load point.

// File: rtl/tmr16_wavegen.sv
module tmr16_wavegen #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] wdata,
  input  logic         wr_cmp_a,
  input  logic         wr_cmp_b,
  input  logic         wr_cap,
  input  logic         wr_mode,
  input  logic         force_a,
  input  logic         force_b,
  input  logic [1:0]   om_a,
  input  logic [1:0]   om_b,
  output logic [W-1:0] count,
  output logic         wave_a,
  output logic         wave_b,
  output logic         ovf,
  output logic         match_a,
  output logic         match_b
);
  localparam logic [W-1:0] MAX = '1;
  localparam logic [1:0] K_DIRECT = 2'd0, K_FAST = 2'd1, K_DUAL = 2'd2, K_HOLD = 2'd3;

  logic [3:0]   mode;
  logic [W-1:0] cnt, cmpa, cmpb, bufa, bufb, cap, top;
  logic         down;
  logic [1:0]   kind;

  always_comb begin
    case (mode)
      4'd1, 4'd5:                top = W'(16'h00FF);
      4'd2, 4'd6:                top = W'(16'h01FF);
      4'd3, 4'd7:                top = W'(16'h03FF);
      4'd4, 4'd9, 4'd11, 4'd15:  top = cmpa;
      4'd8, 4'd10, 4'd12, 4'd14: top = cap;
      default:                   top = MAX;
    endcase
    case (mode)
      4'd0, 4'd4, 4'd12:           kind = K_DIRECT;
      4'd5, 4'd6, 4'd7, 4'd14, 4'd15: kind = K_FAST;
      4'd13:                       kind = K_HOLD;
      default:                     kind = K_DUAL;
    endcase
  end

  wire step     = tick && kind != K_HOLD;
  wire pfc      = mode == 4'd8 || mode == 4'd9;
  wire at_top   = cnt == top;
  wire turn_top = !down && cnt >= top;
  wire turn_bot = down && cnt == '0;
  wire moving_up = (!down && cnt < top) || turn_bot;
  wire hit_a    = step && cnt == cmpa;
  wire hit_b    = step && cnt == cmpb;
  wire wrap_f   = step && kind == K_FAST && at_top;

  wire load = step && ((kind == K_FAST && at_top) ||
                       (kind == K_DUAL && (pfc ? turn_bot : turn_top)));
  wire ovf_evt = step && ((kind == K_DIRECT && cnt == MAX) ||
                          (kind == K_FAST && at_top) ||
                          (kind == K_DUAL && turn_bot));

  function automatic logic pin_nx(input logic cur, input logic [1:0] om, input logic hit,
                                  input logic frc, input logic up, input logic bot,
                                  input logic [1:0] k);
    logic r;
    r = cur;
    case (k)
      K_DIRECT: if (hit || frc) begin
        case (om)
          2'd1:    r = ~cur;
          2'd2:    r = 1'b0;
          2'd3:    r = 1'b1;
          default: r = cur;
        endcase
      end
      K_FAST: if (om[1]) begin
        if (bot)      r = ~om[0];
        else if (hit) r = om[0];
      end
      K_DUAL: if (om[1] && hit) r = up ? om[0] : ~om[0];
      default: r = cur;
    endcase
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; down <= 1'b0; mode <= '0;
      cmpa <= '0; cmpb <= '0; bufa <= '0; bufb <= '0; cap <= '0;
      wave_a <= 1'b0; wave_b <= 1'b0;
      ovf <= 1'b0; match_a <= 1'b0; match_b <= 1'b0;
    end else begin
      if (step) begin
        if (kind == K_DUAL) begin
          if (turn_top)      begin cnt <= cnt - 1'b1; down <= 1'b1; end
          else if (turn_bot) begin cnt <= W'(1);      down <= 1'b0; end
          else               cnt <= down ? cnt - 1'b1 : cnt + 1'b1;
        end else begin
          cnt <= (at_top || cnt == MAX) ? '0 : cnt + 1'b1;
        end
      end
      if (wr_mode) begin mode <= wdata[3:0]; down <= 1'b0; end
      if (load) begin cmpa <= bufa; cmpb <= bufb; end
      if (wr_cmp_a) begin bufa <= wdata; if (kind == K_DIRECT) cmpa <= wdata; end
      if (wr_cmp_b) begin bufb <= wdata; if (kind == K_DIRECT) cmpb <= wdata; end
      if (wr_cap) cap <= wdata;
      wave_a  <= pin_nx(wave_a, om_a, hit_a, force_a, moving_up, wrap_f, kind);
      wave_b  <= pin_nx(wave_b, om_b, hit_b, force_b, moving_up, wrap_f, kind);
      ovf     <= ovf_evt;
      match_a <= hit_a;
      match_b <= hit_b;
    end
  end

  assign count = cnt;

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt) && !ovf && !match_a && !match_b);
  // R12
  reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd13) |=> $stable(cnt) && $stable(wave_a) && $stable(wave_b));
  // R11
  force_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_a && !tick) |=> !match_a);
  // R13
  match_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_a || match_b) |-> $past(tick));
  // R3
  ovf_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> cnt <= W'(1));
  // R8
  fast_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && kind == K_FAST && $past(kind) == K_FAST && $past(om_a) == 2'd2) |-> wave_a);
endmodule

// File: tb/tb_tmr16_wavegen.sv
`timescale 1ns/1ps
module tb_tmr16_wavegen;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [15:0] wdata = '0;
  logic wr_cmp_a = 0, wr_cmp_b = 0, wr_cap = 0, wr_mode = 0, force_a = 0, force_b = 0;
  logic [1:0] om_a = 0, om_b = 0;
  logic [15:0] count;
  logic wave_a, wave_b, ovf, match_a, match_b;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  tmr16_wavegen dut (.clk, .rst_n, .tick, .wdata, .wr_cmp_a, .wr_cmp_b, .wr_cap, .wr_mode,
    .force_a, .force_b, .om_a, .om_b, .count, .wave_a, .wave_b, .ovf, .match_a, .match_b);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; tick = 0; om_a = 0; om_b = 0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1;
  endtask

  task automatic wr(input int sel, input logic [15:0] d);
    @(negedge clk);
    wdata = d;
    wr_cmp_a = (sel == 0); wr_cmp_b = (sel == 1); wr_cap = (sel == 2); wr_mode = (sel == 3);
    @(posedge clk); #1;
    wr_cmp_a = 0; wr_cmp_b = 0; wr_cap = 0; wr_mode = 0;
  endtask

  task automatic run(input int n);
    @(negedge clk) tick = 1;
    repeat (n) @(posedge clk);
    #1 tick = 0;
  endtask

  task automatic strobe(input bit chan_b);
    @(negedge clk);
    if (chan_b) force_b = 1; else force_a = 1;
    @(posedge clk); #1;
    force_a = 0; force_b = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 count", count, 0); chk("R1 pins", {wave_a, wave_b}, 0);
    chk("R1 flags", {ovf, match_a, match_b}, 0);
    repeat (5) @(posedge clk); #1;
    chk("R2 idle count", count, 0);
  endtask

  task automatic t_normal();
    do_reset();
    wr(1, 16'h0002); om_b = 2'd3;
    run(3);
    chk("R3 count", count, 3); chk("R13 match_b", match_b, 1); chk("R10 set", wave_b, 1);
    om_b = 2'd1;
    run(65533);
    chk("R3 wrap", count, 0); chk("R3 ovf", ovf, 1);
    run(3);
    chk("R10 toggle", wave_b, 0);
    om_b = 2'd0; strobe(1);
    chk("R10 action0", wave_b, 0);
  endtask

  task automatic t_ctc();
    do_reset();
    wr(0, 16'h0005); wr(3, 16'd4); om_a = 2'd1;
    run(5); chk("R4 to top", count, 5);
    run(1); chk("R4 clear", count, 0); chk("R13 match_a", match_a, 1); chk("R10 toggle a", wave_a, 1);
    run(3); strobe(0);
    chk("R11 force pin", wave_a, 0); chk("R11 no clear", count, 3); chk("R11 no flag", match_a, 0);
    wr(2, 16'h0003); wr(3, 16'd12);
    run(1); chk("R4 cap top", count, 0);
  endtask

  task automatic t_fast();
    do_reset();
    wr(3, 16'd5); wr(0, 16'h0010); wr(1, 16'h0020); om_a = 2'd2; om_b = 2'd3;
    run(1);
    chk("R7 old cmp match", {match_a, match_b}, 2'b11); chk("R8 a", wave_a, 0); chk("R8 b", wave_b, 1);
    run(254); chk("R5 at top", count, 16'h00FF); chk("R5 no ovf", ovf, 0);
    run(1);
    chk("R5 wrap", count, 0); chk("R5 ovf", ovf, 1); chk("R8 set at wrap", wave_a, 1); chk("R8 inv wrap", wave_b, 0);
    strobe(0); chk("R11 pwm ignore", wave_a, 1);
    run(17);
    chk("R7 new cmp", count, 16'h0011); chk("R8 clear", wave_a, 0); chk("R13 match new", match_a, 1);
    run(16); chk("R8 inv set", wave_b, 1);
    do_reset();
    wr(2, 16'h000F); wr(3, 16'd14);
    run(15); chk("R5 cap top", count, 16'h000F);
    run(1); chk("R5 cap wrap", {count, ovf}, 17'h1);
    do_reset();
    wr(3, 16'd6);
    run(16'h01FF); chk("R5 9-bit top", count, 16'h01FF);
    run(1); chk("R5 9-bit wrap", {count, ovf}, 17'h1);
  endtask

  task automatic t_collide();
    do_reset();
    wr(0, 16'h00FF); wr(3, 16'd5); om_a = 2'd2;
    run(256); chk("R14 pin high", wave_a, 1); chk("R14 flag", match_a, 1);
    run(256); chk("R14 still high", wave_a, 1);
  endtask

  task automatic t_phase();
    do_reset();
    wr(3, 16'd1); wr(0, 16'h0040); om_a = 2'd2;
    run(1); chk("R7 pc old cmp", match_a, 1);
    run(254); chk("R6 up to top", count, 16'h00FF);
    run(1); chk("R6 turn", count, 16'h00FE);
    run(190); chk("R9 before", {count, wave_a}, {16'h0040, 1'b0});
    run(1); chk("R9 down set", wave_a, 1); chk("R7 pc load at top", match_a, 1);
    run(63); chk("R6 bottom", count, 0); chk("R6 no ovf yet", ovf, 0);
    run(1); chk("R6 ovf", {count, ovf}, 17'h3);
    run(64); chk("R9 up clear", {count, wave_a}, {16'h0041, 1'b0});
  endtask

  task automatic t_pfc();
    do_reset();
    wr(0, 16'h0020); wr(1, 16'h0008); wr(3, 16'd9); wr(0, 16'h0030); om_b = 2'd2;
    run(32); chk("R6 pfc top", count, 16'h0020);
    run(1); chk("R7 pfc no load at top", count, 16'h001F);
    run(31); chk("R6 pfc bottom", count, 0); chk("R9 pfc set", wave_b, 1);
    run(1); chk("R6 pfc ovf", ovf, 1);
    run(47); chk("R7 pfc new top", count, 16'h0030); chk("R9 pfc clear", wave_b, 0);
    run(1); chk("R6 pfc turn", count, 16'h002F);
  endtask

  task automatic t_reserved();
    do_reset();
    om_a = 2'd3;
    run(2); chk("R10 set a", {count, wave_a}, {16'h0002, 1'b1});
    wr(3, 16'd13); om_a = 2'd2;
    run(10); chk("R12 hold cnt", count, 2);
    strobe(0); chk("R12 hold pin", wave_a, 1);
    wr(3, 16'd0);
    run(1); chk("R12 resume", count, 3);
  endtask

  initial begin
    t_reset(); t_normal(); t_ctc(); t_fast(); t_collide(); t_phase(); t_pfc(); t_reserved();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule